// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Registers

The block holds a joint translation buffer of `SETS` sets by `WAYS` ways (128 by 2 by default). Each entry is a pair of 32-bit words. The tag word holds the virtual page, the address-space tag, and the valid and global flags. The payload word holds the physical frame and permissions, and the block returns it unchanged. Software or a hardware walker fills and inspects the buffer through five registers on a simple write/read bus: a tag staging word, a payload staging word, a slot pointer, a command trigger and a process-identity register. A command written to the trigger runs at that clock edge. It can probe for an existing entry, pick a victim slot, read a slot, write a slot (with or without a flush of the small per-pipe translation caches), or request only that flush.

A separate lookup port translates a virtual page number under the current process identity. One cycle later it returns hit, payload and a multiple-match flag. The multiple-match flag reports a duplicate entry, and it is raised only at lookup time. The per-pipe caches are not part of the block; it only drives a one-cycle flush pulse toward them.

Top module: `tlb_assoc`

## Requirements
- R1: After reset the tag word, payload word, slot pointer and identity register all read zero, and every entry is invalid.
- R2: A bus write at address 0 (tag word), 1 (payload word), 2 (slot pointer) or 4 (identity) is readable at the same address in the next cycle. Address 3 (command trigger) always reads zero.
- R3: Command 4 (probe) looks at the set given by tag word bits [19:13]. On a match it loads the slot pointer with set*WAYS+way, using the lowest matching way, with bit 31 clear.
- R4: A probe with no matching way loads the slot pointer with 32'h8000_0000 (bit 31 is the miss flag).
- R5: Command 3 (pick slot) loads the slot pointer with set*WAYS+way. The set is tag word bits [19:13]. The way is the low log2(WAYS) bits of an 8-bit shift register that resets to 8'h01, shifts left, and takes bit7^bit5^bit4^bit3 into bit 0. The register advances after each pick.
- R6: Command 1 stores both staging words at the slot given by the low bits of the slot pointer, and drives `uFlush` high in the following cycle.
- R7: Command 5 stores like command 1 but leaves `uFlush` low. Command 6 only pulses `uFlush` and leaves every entry unchanged.
- R8: Command 2 loads both staging words from the slot given by the slot pointer.
- R9: An entry matches when its valid bit (tag bit 8) is set and its page (tag bits [31:13]) equals the requested page. Its address-space tag (bits [7:0]) must also equal the requested one, unless its global bit (bit 9) is set.
- R10: `lkDone` follows `lkReq` by one cycle. `lkHit` and `lkData` (the payload of the lowest matching way, zero on a miss) use the identity register's low 8 bits. When identity bit 31 is clear, a lookup never hits.
- R11: `lkMulti` is high one cycle after an enabled lookup in which more than one way matches.
- R12: Command codes 0 and 7, and any command word with bits above bit 2 set, change no register, no entry and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 tag, 1 payload, 2 slot pointer, 3 command, 4 identity) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the addressed register (combinational) |
| lkReq | input | 1 | Lookup request |
| lkVpn | input | 19 | Virtual page number to translate |
| lkDone | output | 1 | Lookup result valid |
| lkHit | output | 1 | Lookup found a matching entry |
| lkData | output | 32 | Payload word of the hit entry |
| lkMulti | output | 1 | More than one way matched (duplicate entry) |
| uFlush | output | 1 | One-cycle flush pulse for the per-pipe translation caches |

## Verification
The lookup and probe paths are tried with several tag patterns. An exact page and address-space match separates the page compare from the address-space compare. A mismatched address-space tag on a non-global entry must miss, and the same mismatch on a global entry must hit; together these show that the global bit overrides the address-space compare. A second page in the same set must miss on probe, which shows the page compare covers bits above the set index. Two identical entries placed in both ways of one set expose the duplicate flag and the lowest-way priority. Repeated slot picks trace the pseudo-random way sequence, and accesses at slot 255 check the top of the index range.

// File: rtl/tlb_assoc_pkg.sv
package tlb_assoc_pkg;

  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int VALID_BIT  = 8;
  localparam int GLOBAL_BIT = 9;
  localparam int EN_BIT     = 31;
  localparam int MISS_BIT   = 31;

  localparam logic [2:0] RA_TAG   = 3'd0;
  localparam logic [2:0] RA_DATA  = 3'd1;
  localparam logic [2:0] RA_INDEX = 3'd2;
  localparam logic [2:0] RA_CMD   = 3'd3;
  localparam logic [2:0] RA_PID   = 3'd4;

  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_WRITE      = 3'd1,
    CMD_READ       = 3'd2,
    CMD_PICK       = 3'd3,
    CMD_PROBE      = 3'd4,
    CMD_WRITE_KEEP = 3'd5,
    CMD_FLUSH_ONLY = 3'd6,
    CMD_RSVD       = 3'd7
  } cmd_e;

  typedef struct packed {
    logic       ldTag;
    logic       ldData;
    logic       ldIndex;
    logic       ldPid;
    logic       doWrite;
    logic       doRead;
    logic       doPick;
    logic       doProbe;
    logic [1:0] victimWay;
  } strobe_t;

endpackage

// File: rtl/tlb_assoc_ctrl.sv
module tlb_assoc_ctrl
  import tlb_assoc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output strobe_t     stb,
  output logic        uFlush
);

  logic [7:0] lfsr;
  logic       cmdOk;
  cmd_e       cmdCode;
  logic       isCmd;

  assign cmdOk   = (regWdata[31:3] == 29'd0);
  assign cmdCode = cmd_e'(regWdata[2:0]);
  assign isCmd   = regWe && (regAddr == RA_CMD) && cmdOk;

  always_comb begin
    stb = '0;
    stb.victimWay = lfsr[1:0];
    if (regWe) begin
      case (regAddr)
        RA_TAG:   stb.ldTag   = 1'b1;
        RA_DATA:  stb.ldData  = 1'b1;
        RA_INDEX: stb.ldIndex = 1'b1;
        RA_PID:   stb.ldPid   = 1'b1;
        default:  ;
      endcase
    end
    if (isCmd) begin
      case (cmdCode)
        CMD_WRITE, CMD_WRITE_KEEP: stb.doWrite = 1'b1;
        CMD_READ:                  stb.doRead  = 1'b1;
        CMD_PICK:                  stb.doPick  = 1'b1;
        CMD_PROBE:                 stb.doProbe = 1'b1;
        default:                   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr   <= 8'h01;
      uFlush <= 1'b0;
    end else begin
      if (stb.doPick)
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      uFlush <= isCmd && ((cmdCode == CMD_WRITE) || (cmdCode == CMD_FLUSH_ONLY));
    end
  end

  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 8'h00);

  p_flush_after_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_CMD && regWdata == 32'd1) |=> uFlush);

  p_keep_no_flush_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_CMD && regWdata == 32'd5) |=> !uFlush);

  p_rsvd_no_flush_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == RA_CMD && regWdata[2:0] == 3'd7) |=> !uFlush);

endmodule

// File: rtl/tlb_assoc_dp.sv
module tlb_assoc_dp
  import tlb_assoc_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             lkReq,
  input  logic [VPN_W-1:0] lkVpn,
  output logic             lkDone,
  output logic             lkHit,
  output logic [31:0]      lkData,
  output logic             lkMulti
);

  localparam int SB = $clog2(SETS);
  localparam int WB = $clog2(WAYS);
  localparam int IW = SB + WB;
  localparam int NE = SETS * WAYS;

  logic [31:0] tagReg, dataReg, idxReg, pidReg;
  logic [31:0] tagMem  [NE];
  logic [31:0] dataMem [NE];
  logic [NE-1:0] validVec;

  logic [IW-1:0] slot;
  logic [SB-1:0] prbSet, lkSet;
  logic [WAYS-1:0] prbHitVec, lkHitVec;
  logic [WB-1:0] prbWay, lkWay;
  logic          prbAny, lkAny;
  logic [WB:0]   lkCnt;
  logic [31:0]   rdTag;

  assign slot   = idxReg[IW-1:0];
  assign prbSet = tagReg[PAGE_SHIFT +: SB];
  assign lkSet  = lkVpn[SB-1:0];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      logic [IW-1:0] pe, le;
      assign pe = {prbSet, WB'(w)};
      assign le = {lkSet, WB'(w)};
      assign prbHitVec[w] = validVec[pe]
        && (tagMem[pe][31:PAGE_SHIFT] == tagReg[31:PAGE_SHIFT])
        && ((tagMem[pe][ASID_W-1:0] == tagReg[ASID_W-1:0]) || tagMem[pe][GLOBAL_BIT]);
      assign lkHitVec[w] = validVec[le]
        && (tagMem[le][31:PAGE_SHIFT] == lkVpn)
        && ((tagMem[le][ASID_W-1:0] == pidReg[ASID_W-1:0]) || tagMem[le][GLOBAL_BIT]);
    end
  endgenerate

  always_comb begin
    prbAny = 1'b0;
    prbWay = '0;
    lkAny  = 1'b0;
    lkWay  = '0;
    lkCnt  = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (prbHitVec[i]) begin
        prbAny = 1'b1;
        prbWay = WB'(i);
      end
      if (lkHitVec[i]) begin
        lkAny = 1'b1;
        lkWay = WB'(i);
        lkCnt = lkCnt + (WB+1)'(1);
      end
    end
  end

  always_comb begin
    rdTag = tagMem[slot];
    rdTag[VALID_BIT] = validVec[slot];
  end

  always_comb begin
    case (regAddr)
      RA_TAG:   regRdata = tagReg;
      RA_DATA:  regRdata = dataReg;
      RA_INDEX: regRdata = idxReg;
      RA_PID:   regRdata = pidReg;
      default:  regRdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.doWrite) begin
      tagMem[slot]  <= tagReg;
      dataMem[slot] <= dataReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      tagReg   <= '0;
      dataReg  <= '0;
      idxReg   <= '0;
      pidReg   <= '0;
    end else begin
      if (stb.doWrite) validVec[slot] <= tagReg[VALID_BIT];

      if (stb.ldTag)       tagReg <= regWdata;
      else if (stb.doRead) tagReg <= rdTag;

      if (stb.ldData)      dataReg <= regWdata;
      else if (stb.doRead) dataReg <= dataMem[slot];

      if (stb.ldIndex)       idxReg <= regWdata;
      else if (stb.doPick)   idxReg <= 32'({prbSet, stb.victimWay[WB-1:0]});
      else if (stb.doProbe)  idxReg <= prbAny ? 32'({prbSet, prbWay}) : (32'd1 << MISS_BIT);

      if (stb.ldPid) pidReg <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkDone  <= 1'b0;
      lkHit   <= 1'b0;
      lkData  <= '0;
      lkMulti <= 1'b0;
    end else begin
      lkDone  <= lkReq;
      lkHit   <= lkReq && pidReg[EN_BIT] && lkAny;
      lkData  <= (lkReq && pidReg[EN_BIT] && lkAny) ? dataMem[{lkSet, lkWay}] : 32'd0;
      lkMulti <= lkReq && pidReg[EN_BIT] && (lkCnt > (WB+1)'(1));
    end
  end

  p_multi_has_hit_r11: assert property (@(posedge clk) disable iff (!rstN)
    lkMulti |-> lkHit);

  p_lookup_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> lkDone);

  p_off_no_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && !pidReg[EN_BIT]) |=> (!lkHit && !lkMulti));

  p_pick_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.doPick |=> !idxReg[MISS_BIT]);

  p_probe_miss_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doProbe && !prbAny) |=> (idxReg == 32'h8000_0000));

  p_read_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doRead && !stb.ldPid) |=> $stable(pidReg));

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_assoc_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             lkReq,
  input  logic [VPN_W-1:0] lkVpn,
  output logic             lkDone,
  output logic             lkHit,
  output logic [31:0]      lkData,
  output logic             lkMulti,
  output logic             uFlush
);

  strobe_t stb;

  tlb_assoc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .stb      (stb),
    .uFlush   (uFlush)
  );

  tlb_assoc_dp #(.SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .lkReq    (lkReq),
    .lkVpn    (lkVpn),
    .lkDone   (lkDone),
    .lkHit    (lkHit),
    .lkData   (lkData),
    .lkMulti  (lkMulti)
  );

endmodule

// File: tb/tlb_assoc_tb_top.sv
module tlb_assoc_tb_top;

  localparam int SETS = 128;
  localparam int WAYS = 2;
  localparam int NE   = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        lkReq = 1'b0;
  logic [18:0] lkVpn = 19'd0;
  logic        lkDone, lkHit, lkMulti, uFlush;
  logic [31:0] lkData;

  int checks = 0;
  int errors = 0;

  logic [31:0] mTag  [NE];
  logic [31:0] mData [NE];
  bit          mVal  [NE];
  logic [31:0] ePd0 = 0, ePd1 = 0, eIdx = 0, ePid = 0, eLkData = 0;
  logic [7:0]  mLfsr = 8'h01;
  bit          eFlush = 0, eLkDone = 0, eLkHit = 0, eLkMulti = 0;

  always #10 clk = ~clk;

  tlb_assoc #(.SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lkReq(lkReq), .lkVpn(lkVpn),
    .lkDone(lkDone), .lkHit(lkHit), .lkData(lkData), .lkMulti(lkMulti),
    .uFlush(uFlush)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    regAddr = 3'd0; #1 chk(tag, "tag word", regRdata, ePd0);
    regAddr = 3'd1; #1 chk(tag, "payload word", regRdata, ePd1);
    regAddr = 3'd2; #1 chk(tag, "slot pointer", regRdata, eIdx);
    regAddr = 3'd3; #1 chk(tag, "command readback", regRdata, 32'd0);
    regAddr = 3'd4; #1 chk(tag, "identity", regRdata, ePid);
    chk(tag, "uFlush", 32'(uFlush), 32'(eFlush));
    chk(tag, "lkDone", 32'(lkDone), 32'(eLkDone));
    chk(tag, "lkHit", 32'(lkHit), 32'(eLkHit));
    chk(tag, "lkData", lkData, eLkData);
    chk(tag, "lkMulti", 32'(lkMulti), 32'(eLkMulti));
  endtask

  function automatic bit m_match(input int e, input logic [18:0] vpn, input logic [7:0] asid);
    return mVal[e] && (mTag[e][31:13] == vpn) && ((mTag[e][7:0] == asid) || mTag[e][9]);
  endfunction

  // One clock: drive at the falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(input string tag, input bit we, input logic [2:0] addr, input logic [31:0] wd,
                      input bit lk, input logic [18:0] vpn);
    int cnt = 0;
    logic [31:0] d = 0;
    int slot = int'(eIdx[7:0]) % NE;
    int pset = int'(ePd0[19:13]) % SETS;
    for (int w = 0; w < WAYS; w++) begin
      int e = (int'(vpn) % SETS) * WAYS + w;
      if (m_match(e, vpn, ePid[7:0])) begin
        if (cnt == 0) d = mData[e];
        cnt++;
      end
    end
    eLkDone  = lk;
    eLkHit   = lk && ePid[31] && (cnt > 0);
    eLkData  = eLkHit ? d : 32'd0;
    eLkMulti = lk && ePid[31] && (cnt > 1);
    eFlush   = 0;
    if (we) begin
      case (addr)
        3'd0: ePd0 = wd;
        3'd1: ePd1 = wd;
        3'd2: eIdx = wd;
        3'd4: ePid = wd;
        3'd3: begin
          case (wd)
            32'd1, 32'd5: begin
              mTag[slot] = ePd0; mData[slot] = ePd1; mVal[slot] = ePd0[8];
              eFlush = (wd == 32'd1);
            end
            32'd6: eFlush = 1;
            32'd2: begin
              ePd0 = mTag[slot]; ePd0[8] = mVal[slot]; ePd1 = mData[slot];
            end
            32'd3: begin
              eIdx = pset * WAYS + (int'(mLfsr) % WAYS);
              mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
            end
            32'd4: begin
              int hw = -1;
              for (int w = WAYS - 1; w >= 0; w--)
                if (m_match(pset * WAYS + w, ePd0[31:13], ePd0[7:0])) hw = w;
              eIdx = (hw >= 0) ? 32'(pset * WAYS + hw) : 32'h8000_0000;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    regWe = we; regAddr = addr; regWdata = wd; lkReq = lk; lkVpn = vpn;
    @(posedge clk);
    #1 regWe = 1'b0; lkReq = 1'b0;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, 1, a, d, 0, 19'd0);
  endtask

  task automatic look(input string tag, input logic [18:0] v);
    step(tag, 0, 3'd0, 32'd0, 1, v);
  endtask

  function automatic logic [31:0] mk_tag(input logic [18:0] vpn, input bit g, input bit v, input logic [7:0] asid);
    return {vpn, 3'b000, g, v, asid};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin mTag[i] = 0; mData[i] = 0; mVal[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    compare_all("R1");
    // R2 register loads and identity enable
    wr("R2", 3'd4, 32'h8000_0005);
    look("R1", 19'h12345);
    wr("R2", 3'd0, mk_tag(19'h12345, 0, 1, 8'd5));
    wr("R2", 3'd1, 32'hCAFE_0001);
    // R5 pick slot, R6 write with flush, R10 lookup hit
    wr("R5", 3'd3, 32'd3);
    wr("R6", 3'd3, 32'd1);
    step("R6", 0, 3'd0, 32'd0, 0, 19'd0);
    look("R10", 19'h12345);
    // R9 address-space mismatch misses, global entry hits
    wr("R9", 3'd4, 32'h8000_0006);
    look("R9", 19'h12345);
    wr("R9", 3'd0, mk_tag(19'h00777, 1, 1, 8'd9));
    wr("R9", 3'd1, 32'hBEEF_0002);
    wr("R5", 3'd3, 32'd3);
    wr("R7", 3'd3, 32'd5);
    look("R9", 19'h00777);
    // R3 probe hit, R4 probe miss in the same set
    wr("R3", 3'd4, 32'h8000_0005);
    wr("R3", 3'd0, mk_tag(19'h12345, 0, 1, 8'd5));
    wr("R3", 3'd3, 32'd4);
    wr("R4", 3'd0, mk_tag(19'h00045, 0, 1, 8'd5));
    wr("R4", 3'd3, 32'd4);
    // R8 read back the global entry
    wr("R8", 3'd2, 32'd238);
    wr("R8", 3'd0, 32'd0);
    wr("R8", 3'd1, 32'd0);
    wr("R8", 3'd3, 32'd2);
    // R7 flush only leaves entries intact
    wr("R7", 3'd3, 32'd6);
    look("R7", 19'h00777);
    look("R7", 19'h12345);
    // R12 reserved command codes do nothing
    wr("R12", 3'd3, 32'd7);
    wr("R12", 3'd3, 32'd0);
    wr("R12", 3'd3, 32'h0000_0011);
    look("R12", 19'h12345);
    // R11 duplicate entry in way 0 of the same set
    wr("R11", 3'd0, mk_tag(19'h12345, 0, 1, 8'd5));
    wr("R11", 3'd1, 32'h0000_1111);
    wr("R11", 3'd2, 32'd138);
    wr("R11", 3'd3, 32'd5);
    look("R11", 19'h12345);
    wr("R3", 3'd3, 32'd4);
    look("R11", 19'h00045);
    // R6 top slot 255, then read it back with R8
    wr("R6", 3'd0, mk_tag(19'h0007F, 0, 1, 8'd5));
    wr("R6", 3'd1, 32'h5555_AAAA);
    wr("R6", 3'd2, 32'd255);
    wr("R6", 3'd3, 32'd1);
    wr("R8", 3'd0, 32'd0);
    wr("R8", 3'd3, 32'd2);
    look("R10", 19'h0007F);
    // R5 way sequence over several picks
    for (int k = 0; k < 10; k++) wr("R5", 3'd3, 32'd3);
    // R10 translation disabled
    wr("R10", 3'd4, 32'h0000_0005);
    look("R10", 19'h12345);
    look("R10", 19'h0007F);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule